// File: doc/BRIEF.md
# Minifloat Multiplier with Selectable Rounding

This block multiplies two small floating-point words and returns a product of the same width. Each word holds a sign bit in its most significant position, then a biased exponent field, then a stored fraction field in the least significant bits. A leading one that is not stored sits in front of the fraction. The exponent width, the fraction width and the bias are parameters. The defaults give an 8-bit word: 5 exponent bits, 2 stored fraction bits (3 significant bits with the hidden one), and a bias of 15.

Only the significands are multiplied. The exponents are added and the bias is removed. The product is then normalized and rounded back to the stored fraction width. The caller picks one of four rounding directions on every operation. The block has no infinities, no NaNs and no subnormals. A product that is too large is clamped to the largest finite magnitude. A product that is too small becomes a signed zero.

Operands are captured in an input register stage and the result leaves from an output register stage, so the latency is two clock edges. A new operation may enter on every cycle.

Top module: `mfm_mul`

## Requirements
- R1: `out_vld` is high exactly two rising edges after a cycle in which `in_vld` was high, and low otherwise.
- R2: The result sign bit (bit W-1) is the XOR of the two operand sign bits, in every case including zero, flush and saturation.
- R3: With `rnd_mode` = 2, the exact product is rounded to the nearest representable value. Ties go to the value with an even last fraction bit.
- R4: With `rnd_mode` = 0, the exact product is rounded toward minus infinity. A negative inexact product therefore grows in magnitude.
- R5: With `rnd_mode` = 1, the exact product is rounded toward plus infinity. A positive inexact product therefore grows in magnitude.
- R6: With `rnd_mode` = 3, the product is rounded to nearest, and ties go away from zero.
- R7: When rounding carries out of the fraction, the fraction becomes zero and the exponent rises by one.
- R8: If the final biased exponent exceeds the all-ones exponent field, the magnitude is clamped to the all-ones exponent with an all-ones fraction. This applies in every rounding mode.
- R9: If the biased exponent before rounding is below 1, the result is a zero with the sign from R2. The exponent and fraction are all zeros.
- R10: An operand whose exponent field is zero counts as zero, so the result magnitude is zero.
- R11: During and after reset, `out_vld` is 0 and `result` is 0.
- R12: `result` keeps its last value on every cycle in which no new result is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| op_a | input | W | First operand {sign, exponent, fraction} |
| op_b | input | W | Second operand {sign, exponent, fraction} |
| rnd_mode | input | 2 | 0 toward -inf, 1 toward +inf, 2 nearest-even, 3 nearest-away |
| out_vld | output | 1 | Result is valid |
| result | output | W | Rounded product {sign, exponent, fraction} |

## Verification
The bench covers every operand pair of the 8-bit format twice, each time in a different rounding mode. It therefore reaches the following corner cases:
- Exact ties, which a design with the wrong tie rule sends in the wrong direction.
- Negative inexact products, which a design that ignores the sign in the directed modes rounds the wrong way.
- Fractions of all ones that round up, which lose their exponent increment if the carry is dropped.
- Exponents that land one step above the maximum or just below 1, which wrap around instead of clamping or flushing.
- Zero-exponent operands, which come out as tiny nonzero values if they are decoded as normal numbers.

Idle cycles with changing operands expose an output register that is loaded without a valid operation.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

    // Rounding direction selected per operation
    typedef enum logic [1:0] {
        RM_DOWN       = 2'd0,
        RM_UP         = 2'd1,
        RM_NEAR_EVEN  = 2'd2,
        RM_NEAR_AWAY  = 2'd3
    } rnd_mode_e;

    // Outcome class chosen by the packing stage
    typedef enum logic [1:0] {
        CL_ZERO_IN,
        CL_FLUSH,
        CL_SATURATE,
        CL_NORMAL
    } res_class_e;

endpackage

// File: rtl/mfm_sig_mul.sv
module mfm_sig_mul #(
    parameter int MAN_W = 2
) (
    input  logic [MAN_W-1:0] frac_a,
    input  logic [MAN_W-1:0] frac_b,
    output logic [MAN_W-1:0] frac_keep,
    output logic             guard,
    output logic             sticky,
    output logic             norm_up
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-2:0] aligned;

    always_comb begin
        prod    = {1'b1, frac_a} * {1'b1, frac_b};
        norm_up = prod[PROD_W-1];
        // Place the leading one just above bit PROD_W-2 in both cases
        if (norm_up) begin
            aligned = prod[PROD_W-2:0];
        end else begin
            aligned = {prod[PROD_W-3:0], 1'b0};
        end
        frac_keep = aligned[PROD_W-2 -: MAN_W];
        guard     = aligned[PROD_W-2-MAN_W];
        sticky    = |aligned[PROD_W-3-MAN_W:0];
    end

endmodule

// File: rtl/mfm_rounder.sv
module mfm_rounder
    import mfm_pkg::*;
#(
    parameter int MAN_W = 2
) (
    input  logic [MAN_W-1:0] frac_in,
    input  logic             guard,
    input  logic             sticky,
    input  logic             sign,
    input  rnd_mode_e        mode,
    output logic [MAN_W-1:0] frac_out,
    output logic             carry
);
    logic bump;
    logic inexact;

    always_comb begin
        inexact = guard | sticky;
        unique case (mode)
            RM_DOWN:      bump = sign & inexact;
            RM_UP:        bump = ~sign & inexact;
            RM_NEAR_EVEN: bump = guard & (sticky | frac_in[0]);
            RM_NEAR_AWAY: bump = guard;
        endcase
        {carry, frac_out} = {1'b0, frac_in} + {{MAN_W{1'b0}}, bump};
    end

endmodule

// File: rtl/mfm_pack.sv
module mfm_pack
    import mfm_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 2,
    parameter int BIAS  = 15
) (
    input  logic                   sign,
    input  logic [EXP_W-1:0]       exp_a,
    input  logic [EXP_W-1:0]       exp_b,
    input  logic                   norm_up,
    input  logic                   carry,
    input  logic [MAN_W-1:0]       frac_rnd,
    output logic [EXP_W+MAN_W:0]   word
);
    localparam int EXT_W = EXP_W + 3;
    localparam int EMAX  = (1 << EXP_W) - 1;

    logic [EXT_W-1:0] e_pre;
    logic [EXT_W-1:0] e_fin;
    logic             zero_in;
    logic             flush;
    logic             sat;
    res_class_e       cls;

    always_comb begin
        zero_in = (exp_a == '0) || (exp_b == '0);
        e_pre   = EXT_W'(exp_a) + EXT_W'(exp_b) + EXT_W'(norm_up) - EXT_W'(BIAS);
        flush   = e_pre[EXT_W-1] || (e_pre == '0);
        e_fin   = e_pre + EXT_W'(carry);
        sat     = (e_fin > EXT_W'(EMAX));

        if (zero_in) begin
            cls = CL_ZERO_IN;
        end else if (flush) begin
            cls = CL_FLUSH;
        end else if (sat) begin
            cls = CL_SATURATE;
        end else begin
            cls = CL_NORMAL;
        end

        unique case (cls)
            CL_ZERO_IN:  word = {sign, {(EXP_W+MAN_W){1'b0}}};
            CL_FLUSH:    word = {sign, {(EXP_W+MAN_W){1'b0}}};
            CL_SATURATE: word = {sign, {(EXP_W+MAN_W){1'b1}}};
            CL_NORMAL:   word = {sign, e_fin[EXP_W-1:0], frac_rnd};
        endcase
    end

endmodule

// File: rtl/mfm_mul.sv
module mfm_mul
    import mfm_pkg::*;
#(
    parameter int EXP_W = 5,
    parameter int MAN_W = 2,
    parameter int BIAS  = (1 << (EXP_W - 1)) - 1,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   rnd_mode,
    output logic         out_vld,
    output logic [W-1:0] result
);
    // Input register stage
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    rnd_mode_e    mode_q;
    logic         vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= RM_DOWN;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                a_q    <= op_a;
                b_q    <= op_b;
                mode_q <= rnd_mode_e'(rnd_mode);
            end
        end
    end

    // Datapath between the register stages
    logic             sign_p;
    logic [MAN_W-1:0] frac_keep;
    logic             guard;
    logic             sticky;
    logic             norm_up;
    logic [MAN_W-1:0] frac_rnd;
    logic             carry;
    logic [W-1:0]     packed_word;

    assign sign_p = a_q[W-1] ^ b_q[W-1];

    mfm_sig_mul #(.MAN_W(MAN_W)) u_sig (
        .frac_a    (a_q[MAN_W-1:0]),
        .frac_b    (b_q[MAN_W-1:0]),
        .frac_keep (frac_keep),
        .guard     (guard),
        .sticky    (sticky),
        .norm_up   (norm_up)
    );

    mfm_rounder #(.MAN_W(MAN_W)) u_rnd (
        .frac_in  (frac_keep),
        .guard    (guard),
        .sticky   (sticky),
        .sign     (sign_p),
        .mode     (mode_q),
        .frac_out (frac_rnd),
        .carry    (carry)
    );

    mfm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_pack (
        .sign     (sign_p),
        .exp_a    (a_q[MAN_W +: EXP_W]),
        .exp_b    (b_q[MAN_W +: EXP_W]),
        .norm_up  (norm_up),
        .carry    (carry),
        .frac_rnd (frac_rnd),
        .word     (packed_word)
    );

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            result  <= '0;
        end else begin
            out_vld <= vld_q;
            if (vld_q) begin
                result <= packed_word;
            end
        end
    end

endmodule

// File: rtl/mfm_mul_chk.sv
module mfm_mul_chk #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 2,
    localparam int W    = 1 + EXP_W + MAN_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         vld_q,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic         out_vld,
    input logic [W-1:0] result
);
    // R1: output valid follows the input stage by one edge
    p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(vld_q));

    // R2: sign of a delivered result is the XOR of captured operand signs
    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (result[W-1] == $past(a_q[W-1] ^ b_q[W-1])));

    // R10: a zero-exponent operand yields a zero magnitude
    p_zero_operand_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($past(a_q[MAN_W +: EXP_W]) == '0 || $past(b_q[MAN_W +: EXP_W]) == '0))
        |-> (result[W-2:0] == '0));

    // R9: a zero exponent field on the output always carries a zero fraction
    p_flush_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && result[MAN_W +: EXP_W] == '0) |-> (result[MAN_W-1:0] == '0));

    // R12: no delivery means the result holds
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(result));

endmodule

bind mfm_mul mfm_mul_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mfm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_q   (vld_q),
    .a_q     (a_q),
    .b_q     (b_q),
    .out_vld (out_vld),
    .result  (result)
);

// File: tb/test_mfm_mul.sv
module test_mfm_mul;
    localparam int EXP_W = 5;
    localparam int MAN_W = 2;
    localparam int BIAS  = 15;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   rnd_mode = '0;
    logic         out_vld;
    logic [W-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mfm_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) i_mfm_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .op_a     (op_a),
        .op_b     (op_b),
        .rnd_mode (rnd_mode),
        .out_vld  (out_vld),
        .result   (result)
    );

    // Expected-value pipe, two entries deep
    logic [W-1:0] pe_res [2];
    logic         pe_vld [2];
    string        pe_tag [2];
    logic [W-1:0] last_res = '0;

    task automatic check(input string tag, input int got, input int exp_v);
        n_chk++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp_v);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input int mode, output logic [W-1:0] r,
                                  output string tag);
        int ea, eb, ma, mb, p, e, sh, keep, rem, half, inc;
        bit sgn;
        sgn = a[7] ^ b[7];
        ea  = int'(a[6:2]);
        eb  = int'(b[6:2]);
        ma  = int'(a[1:0]);
        mb  = int'(b[1:0]);
        tag = (mode == 0) ? "R4" : (mode == 1) ? "R5" : (mode == 2) ? "R3" : "R6";
        if (ea == 0 || eb == 0) begin
            r = {sgn, 7'd0};
            tag = "R10";
            return;
        end
        p = (4 + ma) * (4 + mb);
        e = ea + eb - BIAS;
        if (p >= 32) begin
            e  = e + 1;
            sh = 3;
        end else begin
            sh = 2;
        end
        keep = p >> sh;
        rem  = p - (keep << sh);
        half = 1 << (sh - 1);
        if (e < 1) begin
            r = {sgn, 7'd0};
            tag = "R9";
            return;
        end
        case (mode)
            0:       inc = (sgn && rem != 0) ? 1 : 0;
            1:       inc = (!sgn && rem != 0) ? 1 : 0;
            2:       inc = (rem > half || (rem == half && keep % 2 == 1)) ? 1 : 0;
            default: inc = (rem >= half) ? 1 : 0;
        endcase
        keep = keep + inc;
        if (keep == 8) begin
            keep = 4;
            e    = e + 1;
            tag  = "R7";
        end
        if (e > 31) begin
            r = {sgn, 7'h7f};
            tag = "R8";
        end else begin
            r = {sgn, e[4:0], keep[1:0]};
        end
    endfunction

    // One cycle: check the output due now, then drive the next inputs
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input int mode);
        logic [W-1:0] r;
        string        tg;
        @(negedge clk);
        check("R1 out_vld", int'(out_vld), int'(pe_vld[1]));
        if (pe_vld[1]) begin
            check(pe_tag[1], int'(result), int'(pe_res[1]));
            check("R2 sign", int'(result[7]), int'(pe_res[1][7]));
            last_res = pe_res[1];
        end else begin
            check("R12 hold", int'(result), int'(last_res));
        end
        pe_vld[1] = pe_vld[0];
        pe_res[1] = pe_res[0];
        pe_tag[1] = pe_tag[0];
        model(a, b, mode, r, tg);
        pe_vld[0] = v;
        pe_res[0] = r;
        pe_tag[0] = tg;
        in_vld   = v;
        op_a     = a;
        op_b     = b;
        rnd_mode = 2'(mode);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        pe_vld[0] = 1'b0;
        pe_vld[1] = 1'b0;
        pe_res[0] = '0;
        pe_res[1] = '0;
        pe_tag[0] = "";
        pe_tag[1] = "";
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 out_vld", int'(out_vld), 0);
        check("R11 result", int'(result), 0);
        rst_n = 1'b1;
        // R11/R12: idle after reset keeps zero
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 8'(i * 37), 8'(i * 91), i);
        end
        // Full sweeps, two modes per operand pair (R3..R10)
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    step(1'b1, 8'(a), 8'(b), (a + b + 2 * pass) & 3);
                end
            end
        end
        // R12: idle cycles with moving operands must not disturb result
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 8'(8'h55 + i), 8'(8'hA3 - i), i & 3);
        end
        // R1: isolated operations separated by gaps
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 8'(8'h3C + i), 8'(8'hC1 + 3 * i), i & 3);
            step(1'b0, 8'hFF, 8'hFF, 0);
            step(1'b0, 8'h00, 8'h00, 1);
        end
        step(1'b0, 8'h00, 8'h00, 0);
        step(1'b0, 8'h00, 8'h00, 0);
        report();
    end

endmodule